// File: doc/BRIEF.md
# Byte-Serial Command Deserializer

This block listens to an 8-bit command bus that carries one byte per clock. A strobe marks the first byte of each command. The block assembles a 16-bit address from the first two bytes and then a fixed number of data bytes. It compares the address against a base value, and only the bits selected by a mask take part in the comparison. When the address matches, the block issues one parallel register write, made of a one-cycle enable, the low address bits and the assembled data word.

The sender may transmit up to six bytes per command. The receiver is built to take only as many bytes as its parameter asks for, and anything that follows is discarded. A strobe that arrives before a command is complete throws the partial command away and starts a new one. The address and data outputs are registers that change only in the cycle of a write, so a consumer can also read them later.

Top module: `cmd_byte_deser`

## Requirements
- R1: The first byte of a command is address bits 7:0 and the second is address bits 15:8. Data bytes follow least significant first, so byte 2 becomes data bits 7:0 and byte 3 becomes data bits 15:8.
- R2: A byte is taken as the start of a command only when the strobe is high with it. Bytes that arrive without a strobe while no command is open produce no write and leave the outputs unchanged.
- R3: A command produces a write only when (address XOR BASE_ADDR) AND ADDR_MASK is zero. Address bits outside the mask do not matter. A non-matching command leaves the outputs unchanged.
- R4: The write enable is high for exactly one cycle. That cycle follows the clock edge that samples byte number CAPTURE_BYTES-1, counting the strobed byte as byte 0. A strobe sampled at edge n therefore gives the enable in the cycle after edge n+CAPTURE_BYTES-1.
- R5: In the write cycle, the address output holds the low ADDR_WIDTH bits of the 16-bit address, and the data output holds the low DATA_WIDTH bits of the assembled data bytes.
- R6: Bytes beyond CAPTURE_BYTES in a command are ignored. The address and data outputs change only in a write cycle.
- R7: A strobe before the last captured byte of a command aborts that command without a write. The strobed byte starts a new command.
- R8: Synchronous reset clears any open command, the write enable, and the address and data outputs to zero.
- R9: A strobe in the cycle right after the last captured byte starts a new command, so commands can follow each other with no gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmdByte | input | 8 | Command byte stream |
| cmdStb | input | 1 | High with the first byte of a command |
| wrAddr | output | ADDR_WIDTH | Low address bits of the accepted command |
| wrData | output | DATA_WIDTH | Assembled data of the accepted command |
| wrEn | output | 1 | One-cycle write enable |

## Verification
The bench runs with a 4-byte capture and a 12-bit data width, so the sender's fifth and sixth bytes and the top nibble of the second data byte must all be dropped. Directed commands cover several cases: a full six-byte match, an address that differs in a masked bit, and one that differs only in unmasked bits. They also cover a command aborted by an early strobe, two commands sent back to back, stray bytes with no strobe, and a reset in mid-command. Between them these cases separate the byte order, the mask polarity, the abort rule and the end-of-capture point. Random traffic then mixes matching and random addresses, lengths from one to six bytes and idle gaps, and checks write timing and outputs against a scoreboard every cycle.

// File: rtl/cmd_deser_pkg.sv
package cmd_deser_pkg;

  // Strobes from control to datapath for the byte sampled this cycle.
  typedef struct packed {
    logic       loadLo;    // byte is address low
    logic       loadHi;    // byte is address high
    logic       loadData;  // byte is a data byte
    logic [1:0] dataSlot;  // which data byte (0 = least significant)
    logic       commit;    // last captured byte of a matching command
  } deserCtl_t;

  localparam int MAX_CMD_BYTES = 6;

endpackage

// File: rtl/cmd_deser_ctrl.sv
module cmd_deser_ctrl
  import cmd_deser_pkg::*;
#(
  parameter int CAPTURE_BYTES = 3
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      cmdStb,
  input  logic      addrHit,
  output deserCtl_t ctl,
  output logic      weOut
);

  localparam int CW = $clog2(MAX_CMD_BYTES + 1);
  localparam logic [CW-1:0] LAST_IDX = CW'(CAPTURE_BYTES - 1);

  logic          busy;
  logic [CW-1:0] cnt;
  logic [CW-1:0] curIdx;
  logic [CW-1:0] slotW;
  logic          take;
  logic          lastByte;

  always_comb begin
    curIdx       = cmdStb ? '0 : cnt;
    take         = cmdStb | busy;
    slotW        = curIdx - CW'(2);
    lastByte     = take && (curIdx == LAST_IDX);
    ctl.loadLo   = take && (curIdx == CW'(0));
    ctl.loadHi   = take && (curIdx == CW'(1));
    ctl.loadData = take && (curIdx >= CW'(2));
    ctl.dataSlot = slotW[1:0];
    ctl.commit   = lastByte && addrHit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      cnt   <= '0;
      weOut <= 1'b0;
    end else begin
      weOut <= ctl.commit;
      if (take) begin
        if (lastByte) begin
          busy <= 1'b0;
          cnt  <= '0;
        end else begin
          busy <= 1'b1;
          cnt  <= curIdx + CW'(1);
        end
      end
    end
  end

  assert_we_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    weOut |=> !weOut);

  assert_restart_R7: assert property (@(posedge clk) disable iff (rst)
    cmdStb |=> (busy && cnt == CW'(1)));

  assert_cnt_range_R2: assert property (@(posedge clk) disable iff (rst)
    (busy |-> cnt < CW'(CAPTURE_BYTES)) and (!busy |-> cnt == '0));

  assert_reset_clear_R8: assert property (@(posedge clk)
    rst |=> (!weOut && !busy));

endmodule

// File: rtl/cmd_deser_dp.sv
module cmd_deser_dp
  import cmd_deser_pkg::*;
#(
  parameter logic [15:0] BASE_ADDR     = 16'h0702,
  parameter logic [15:0] ADDR_MASK     = 16'h07FF,
  parameter int          ADDR_WIDTH    = 1,
  parameter int          DATA_WIDTH    = 8,
  parameter int          CAPTURE_BYTES = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [7:0]            byteIn,
  input  deserCtl_t             ctl,
  output logic                  addrHit,
  output logic [ADDR_WIDTH-1:0] addrOut,
  output logic [DATA_WIDTH-1:0] dataOut
);

  localparam int DATA_BYTES = CAPTURE_BYTES - 2;
  localparam int SHW        = 8 * DATA_BYTES;

  logic [15:0]    addrReg;
  logic [SHW-1:0] dataSh;
  logic [SHW-1:0] nextSh;

  // Data bytes with the current byte merged into its slot.
  for (genvar j = 0; j < DATA_BYTES; j++) begin : gSlot
    assign nextSh[8*j +: 8] = (ctl.loadData && ctl.dataSlot == 2'(j)) ? byteIn
                                                                      : dataSh[8*j +: 8];
  end

  assign addrHit = ((addrReg ^ BASE_ADDR) & ADDR_MASK) == 16'h0000;

  always_ff @(posedge clk) begin
    if (rst) begin
      addrReg <= '0;
      dataSh  <= '0;
      addrOut <= '0;
      dataOut <= '0;
    end else begin
      if (ctl.loadLo)   addrReg[7:0]  <= byteIn;
      if (ctl.loadHi)   addrReg[15:8] <= byteIn;
      if (ctl.loadData) dataSh        <= nextSh;
      if (ctl.commit) begin
        addrOut <= addrReg[ADDR_WIDTH-1:0];
        dataOut <= nextSh[DATA_WIDTH-1:0];
      end
    end
  end

  assert_no_commit_early_R1: assert property (@(posedge clk) disable iff (rst)
    ctl.commit |-> (!ctl.loadLo && !ctl.loadHi && ctl.loadData));

endmodule

// File: rtl/cmd_byte_deser.sv
module cmd_byte_deser
  import cmd_deser_pkg::*;
#(
  parameter logic [15:0] BASE_ADDR     = 16'h0702,
  parameter logic [15:0] ADDR_MASK     = 16'h07FF,
  parameter int          ADDR_WIDTH    = 1,
  parameter int          DATA_WIDTH    = 8,
  parameter int          CAPTURE_BYTES = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [7:0]            cmdByte,
  input  logic                  cmdStb,
  output logic [ADDR_WIDTH-1:0] wrAddr,
  output logic [DATA_WIDTH-1:0] wrData,
  output logic                  wrEn
);

  deserCtl_t ctl;
  logic      addrHit;

  cmd_deser_ctrl #(
    .CAPTURE_BYTES(CAPTURE_BYTES)
  ) uCtrl (
    .clk    (clk),
    .rst    (rst),
    .cmdStb (cmdStb),
    .addrHit(addrHit),
    .ctl    (ctl),
    .weOut  (wrEn)
  );

  cmd_deser_dp #(
    .BASE_ADDR    (BASE_ADDR),
    .ADDR_MASK    (ADDR_MASK),
    .ADDR_WIDTH   (ADDR_WIDTH),
    .DATA_WIDTH   (DATA_WIDTH),
    .CAPTURE_BYTES(CAPTURE_BYTES)
  ) uDp (
    .clk    (clk),
    .rst    (rst),
    .byteIn (cmdByte),
    .ctl    (ctl),
    .addrHit(addrHit),
    .addrOut(wrAddr),
    .dataOut(wrData)
  );

  assert_hold_outputs_R6: assert property (@(posedge clk) disable iff (rst)
    !wrEn |-> ($stable(wrAddr) && $stable(wrData)));

endmodule

// File: tb/tb_cmd_byte_deser.sv
module tb_cmd_byte_deser;

  localparam logic [15:0] BASE = 16'h0350;
  localparam logic [15:0] MASK = 16'hFFF0;
  localparam int AW  = 4;
  localparam int DW  = 12;
  localparam int CAP = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [7:0]    cmdByte = 8'h00;
  logic          cmdStb = 1'b0;
  logic [AW-1:0] wrAddr;
  logic [DW-1:0] wrData;
  logic          wrEn;

  cmd_byte_deser #(
    .BASE_ADDR(BASE), .ADDR_MASK(MASK), .ADDR_WIDTH(AW),
    .DATA_WIDTH(DW), .CAPTURE_BYTES(CAP)
  ) dut (
    .clk(clk), .rst(rst), .cmdByte(cmdByte), .cmdStb(cmdStb),
    .wrAddr(wrAddr), .wrData(wrData), .wrEn(wrEn)
  );

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int nChecks = 0;
  int nErr = 0;
  int nWrites = 0;
  bit monOn = 1'b0;
  int            qCyc[$];
  logic [AW-1:0] qAddr[$];
  logic [DW-1:0] qData[$];
  logic [AW-1:0] lastAddr = '0;
  logic [DW-1:0] lastData = '0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit isMatch(input logic [15:0] a);
    return ((a ^ BASE) & MASK) == 16'h0000;
  endfunction

  function automatic logic [DW-1:0] expData(input logic [31:0] d);
    return d[DW-1:0];
  endfunction

  // Scoreboard monitor, sampled at the falling edge.
  always @(negedge clk) begin
    if (monOn) begin
      if (wrEn) begin
        nWrites++;
        check(qCyc.size() > 0 && qCyc[0] == cyc, "R4", "write pulse cycle",
              cyc, (qCyc.size() > 0) ? qCyc[0] : -1);
        if (qCyc.size() > 0 && qCyc[0] == cyc) begin
          check(wrAddr == qAddr[0], "R5", "write address", wrAddr, qAddr[0]);
          check(wrData == qData[0], "R1", "write data", wrData, qData[0]);
          lastAddr = qAddr[0];
          lastData = qData[0];
          void'(qCyc.pop_front());
          void'(qAddr.pop_front());
          void'(qData.pop_front());
        end
      end else begin
        if (qCyc.size() > 0 && qCyc[0] <= cyc) begin
          check(1'b0, "R4", "missing write pulse", cyc, qCyc[0]);
          void'(qCyc.pop_front());
          void'(qAddr.pop_front());
          void'(qData.pop_front());
        end
        check(wrAddr == lastAddr && wrData == lastData, "R3/R6",
              "outputs held between writes", {wrAddr, wrData}, {lastAddr, lastData});
      end
    end
  end

  // Called at a falling edge; returns at a falling edge.
  task automatic sendCmd(input logic [15:0] a, input logic [31:0] d, input int nb);
    logic [7:0] b [6];
    b[0] = a[7:0];  b[1] = a[15:8];
    b[2] = d[7:0];  b[3] = d[15:8];
    b[4] = d[23:16]; b[5] = d[31:24];
    for (int k = 0; k < nb; k++) begin
      cmdByte = b[k];
      cmdStb  = (k == 0);
      if (k == 0 && nb >= CAP && isMatch(a)) begin
        qCyc.push_back(cyc + CAP);
        qAddr.push_back(a[AW-1:0]);
        qData.push_back(expData(d));
      end
      @(negedge clk);
    end
    cmdStb = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      cmdStb  = 1'b0;
      cmdByte = 8'($urandom);
      @(negedge clk);
    end
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    nChecks++;
    nErr++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
    finishRun();
  end

  initial begin
    int w0;
    void'($urandom(32'h1234_5678));
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(wrEn == 1'b0, "R8", "wrEn in reset", wrEn, 0);
    check(wrAddr == '0 && wrData == '0, "R8", "outputs in reset", {wrAddr, wrData}, 0);
    rst = 1'b0;
    @(negedge clk);
    monOn = 1'b1;

    // R1 R5 R6: full six-byte match, extra bytes and high data bits dropped
    w0 = nWrites;
    sendCmd(16'h0357, 32'hA5C3_9E12, 6);
    idle(3);
    check(nWrites - w0 == 1, "R1", "writes for six-byte command", nWrites - w0, 1);
    check(wrData == 12'hE12, "R6", "data after ignored bytes", wrData, 12'hE12);

    // R3: masked bit differs -> no write
    w0 = nWrites;
    sendCmd(16'h0457, 32'h1111_2222, 6);
    idle(3);
    check(nWrites == w0, "R3", "writes for mismatched address", nWrites - w0, 0);

    // R3: only unmasked bits differ -> accepted
    w0 = nWrites;
    sendCmd(16'h035F, 32'h0000_0ABC, 4);
    idle(3);
    check(nWrites - w0 == 1, "R3", "writes for unmasked difference", nWrites - w0, 1);
    check(wrAddr == 4'hF, "R5", "address low bits", wrAddr, 4'hF);

    // R2: bytes without strobe look like a matching command
    w0 = nWrites;
    cmdStb = 1'b0;
    cmdByte = 8'h51; @(negedge clk);
    cmdByte = 8'h03; @(negedge clk);
    cmdByte = 8'h77; @(negedge clk);
    cmdByte = 8'h66; @(negedge clk);
    idle(3);
    check(nWrites == w0, "R2", "writes for unstrobed bytes", nWrites - w0, 0);

    // R7: abort after three bytes, new command completes
    w0 = nWrites;
    sendCmd(16'h0351, 32'h0000_0333, 3);
    sendCmd(16'h0352, 32'h0000_0444, 4);
    idle(3);
    check(nWrites - w0 == 1, "R7", "writes after abort", nWrites - w0, 1);
    check(wrAddr == 4'h2 && wrData == 12'h444, "R7", "outputs after abort",
          {wrAddr, wrData}, {4'h2, 12'h444});

    // R9: back-to-back commands
    w0 = nWrites;
    sendCmd(16'h0353, 32'h0000_0555, 4);
    sendCmd(16'h0354, 32'h0000_0666, 4);
    idle(3);
    check(nWrites - w0 == 2, "R9", "back-to-back writes", nWrites - w0, 2);

    // R8: reset in mid-command
    w0 = nWrites;
    sendCmd(16'h0355, 32'h0000_0777, 2);
    monOn = 1'b0;
    rst = 1'b1;
    cmdByte = 8'h88;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    check(wrAddr == '0 && wrData == '0 && !wrEn, "R8", "outputs after reset",
          {wrEn, wrAddr, wrData}, 0);
    lastAddr = '0;
    lastData = '0;
    monOn = 1'b1;
    idle(4);
    check(nWrites == w0, "R8", "no write from reset-cut command", nWrites - w0, 0);

    // Random traffic
    for (int i = 0; i < 400; i++) begin
      logic [15:0] a;
      logic [31:0] d;
      int nb;
      a  = ($urandom % 2) ? {12'h035, 4'($urandom)} : 16'($urandom);
      d  = $urandom;
      nb = 1 + ($urandom % 6);
      sendCmd(a, d, nb);
      if (nb >= CAP) idle($urandom % 4);
    end
    idle(8);
    check(qCyc.size() == 0, "R4", "pending expected writes", qCyc.size(), 0);
    finishRun();
  end

endmodule